// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces DRAM refresh for a memory controller. A free-running prescaler produces a one-cycle tick. A 3-bit rate select picks how often that tick fires. Each tick advances an 8-bit interval counter. When the counter holds the programmed compare value on a tick, it returns to zero and a refresh match occurs.

When refresh is enabled, a match raises a request towards the bus arbiter. The block then waits for a grant and tracks the refresh cycle until the DRAM side reports completion. Matches that arrive while a request is pending or a refresh is running are discarded. A saturating counter records each discarded match.

Software loads the counter and the compare value while the rate select is zero, which keeps the counter stopped. It then writes a non-zero select, which starts the count.

Top module: `refresh_timer`

## Requirements
- R1: After reset, `count`, `drop_count`, `refresh_req` and `busy` are all 0, and the rate select is 0.
- R2: While the rate select is 0, `count` keeps its value, except when `cnt_we` writes it.
- R3: Select codes 1 to 7 produce a tick every 2, 8, 32, 128, 512, 2048 and 4096 clock cycles. With refresh enabled and the handshake answered at once, rising edges of `refresh_req` are spaced by (compare+1) × that period.
- R4: On a tick where `count` equals the compare value, `count` becomes 0. On any other tick, `count` increments. When refresh is enabled and the block is idle, `refresh_req` rises on the clock edge after the matching tick.
- R5: With `ctl_en`=0, `count` still advances and wraps, but `refresh_req` never rises and `drop_count` does not change.
- R6: `refresh_req` stays high until `grant` is sampled high. `busy` is then high from the next cycle until a cycle in which `done` is sampled high.
- R7: A match while `refresh_req` is pending does not create a new request and adds 1 to `drop_count`.
- R8: A match while `busy` is high does not raise `refresh_req` and adds 1 to `drop_count`.
- R9: `drop_count` saturates at 255.
- R10: In a cycle with `cnt_we` high, `count` takes `cnt_wdata`, whatever the tick does. That cycle produces no match and no request.
- R11: `ctl_we` loads `ctl_en` and `ctl_sel` together. `cmp_we` loads the compare value, which is used from the next tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_we | input | 1 | Interval counter write strobe |
| cnt_wdata | input | 8 | Interval counter write value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare register write value |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Refresh request enable |
| ctl_sel | input | 3 | Tick rate select (0 stops the counter) |
| grant | input | 1 | Bus granted to the refresh cycle |
| done | input | 1 | Refresh cycle finished |
| count | output | 8 | Current interval counter value |
| refresh_req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | Refresh cycle in progress |
| drop_count | output | 8 | Saturating count of discarded matches |

## Verification
The assertions assume that `grant` is only meaningful while a request is pending. They also assume that `done` is only meaningful while a refresh is running, so that stray values in other states have no effect. The stimulus either ties both signals high, for prompt service, or pulses them one cycle after the state they answer has been observed. Register writes are applied only at idle points of the sweep, except in the write-priority test.

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 12,
  parameter int DROP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ctl_we,
  input  logic             ctl_en,
  input  logic [2:0]       ctl_sel,
  input  logic             grant,
  input  logic             done,
  output logic [CNT_W-1:0] count,
  output logic             refresh_req,
  output logic             busy,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BUSY} state_t;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cmp;
  logic             en;
  logic [2:0]       sel;
  logic [3:0]       lg;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;
  logic             tick, match, accept, drop;
  state_t           state;

  always_comb begin
    case (sel)
      3'd1:    lg = 4'd1;
      3'd2:    lg = 4'd3;
      3'd3:    lg = 4'd5;
      3'd4:    lg = 4'd7;
      3'd5:    lg = 4'd9;
      3'd6:    lg = 4'd11;
      default: lg = 4'd12;
    endcase
  end

  assign span   = ((PRE_W+1)'(1) << lg) - (PRE_W+1)'(1);
  assign mask   = span[PRE_W-1:0];
  assign tick   = (sel != 3'd0) && ((pre & mask) == mask);
  assign match  = tick && !cnt_we && (count == cmp);
  assign accept = match && en && (state == S_IDLE);
  assign drop   = match && en && (state != S_IDLE);

  assign refresh_req = (state == S_REQ);
  assign busy        = (state == S_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cmp <= '0;
      en  <= 1'b0;
      sel <= 3'd0;
    end else begin
      pre <= pre + 1'b1;
      if (cmp_we) cmp <= cmp_wdata;
      if (ctl_we) begin
        en  <= ctl_en;
        sel <= ctl_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_we) count <= cnt_wdata;
    else if (match)  count <= '0;
    else if (tick)   count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE:  if (accept) state <= S_REQ;
        S_REQ:   if (grant)  state <= S_BUSY;
        S_BUSY:  if (done)   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_count <= '0;
    else if (drop && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
  end

  p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_we) |=> $stable(count));
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !grant) |=> refresh_req);
  p_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && grant) |=> (busy && !refresh_req));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && !refresh_req));
  p_drop_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == DROP_MAX) |=> (drop_count == DROP_MAX));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
  p_no_req_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !refresh_req) |=> !refresh_req);
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_req && busy));
endmodule

// File: tb/sim_refresh_timer.sv
module sim_refresh_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_we = 0, cmp_we = 0, ctl_we = 0, ctl_en = 0, grant = 0, done = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [2:0] ctl_sel = 0;
  logic [7:0] count, drop_count;
  logic       refresh_req, busy;

  int checks = 0, fails = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .ctl_sel(ctl_sel), .grant(grant), .done(done), .count(count),
    .refresh_req(refresh_req), .busy(busy), .drop_count(drop_count)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic [2:0] sel);
    @(negedge clk); ctl_we = 1; ctl_en = en; ctl_sel = sel;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    @(negedge clk); cmp_we = 1; cmp_wdata = v;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic wait_rise(input int lim, output longint at);
    logic prev;
    prev = refresh_req;
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (refresh_req && !prev) begin at = cyc; break; end
      prev = refresh_req;
    end
  endtask

  task automatic measure(input string req, input int sel, input int cmpv);
    longint t0, t1, t2;
    int period, lim;
    period = (sel == 7) ? 4096 : (1 << (2 * sel - 1));
    lim = period * (cmpv + 1) * 2 + 50;
    wr_ctl(0, 0);
    wr_cmp(8'(cmpv));
    wr_cnt(0);
    wr_ctl(1, 3'(sel));
    wait_rise(lim, t0);
    wait_rise(lim, t1);
    wait_rise(lim, t2);
    chk(req, t1 - t0, longint'(period) * (cmpv + 1));
    chk(req, t2 - t1, longint'(period) * (cmpv + 1));
  endtask

  initial begin
    longint t;
    int d0, seen;
    logic ok;
    #50000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint t;
    int d0;
    logic ok, wrapped;
    logic [7:0] prevc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 req", refresh_req, 0);
    chk("R1 busy", busy, 0);
    chk("R1 drops", drop_count, 0);

    // R2 stopped while select is zero; R10 write loads
    wr_cnt(8'd5);
    chk("R10 write", count, 5);
    repeat (100) @(negedge clk);
    chk("R2 stopped", count, 5);

    // R3/R4/R11 period sweeps with prompt handshake
    grant = 1; done = 1;
    for (int s = 1; s <= 7; s++) measure("R3 rate", s, 2);
    for (int c = 3; c <= 20; c++) measure("R4 compare", 1, c);
    measure("R11 compare reload", 2, 5);

    // R5 disabled: counts and wraps, no request
    wr_ctl(0, 0); wr_cmp(8'd3); wr_cnt(0);
    wr_ctl(0, 3'd1);
    ok = 1; wrapped = 0; prevc = count;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (refresh_req) ok = 0;
      if (prevc == 8'd3 && count == 8'd0) wrapped = 1;
      prevc = count;
    end
    chk("R5 no request", ok, 1);
    chk("R5 still wraps", wrapped, 1);

    // R10 write priority over tick and clear
    wr_ctl(1, 3'd1);
    @(negedge clk); cnt_we = 1; cnt_wdata = 8'd3;
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (count != 8'd3 || refresh_req) ok = 0;
    end
    cnt_we = 0;
    chk("R10 write priority", ok, 1);

    // R7 matches while request pending
    wr_ctl(0, 0); grant = 0; done = 0;
    @(negedge clk); done = 1; @(negedge clk); done = 0;
    wr_cnt(0); wr_ctl(1, 3'd1);
    wait_rise(100, t);
    d0 = drop_count;
    ok = 1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!refresh_req) ok = 0;
    end
    chk("R7 req held", ok, 1);
    chk("R7 drops", drop_count - d0, 10);

    // R6 grant -> busy; R8 matches while busy
    grant = 1; @(negedge clk); grant = 0;
    chk("R6 busy after grant", busy, 1);
    chk("R6 req dropped", refresh_req, 0);
    d0 = drop_count;
    ok = 1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (!busy || refresh_req) ok = 0;
    end
    chk("R8 busy held, no req", ok, 1);
    chk("R8 drops", drop_count - d0, 8);
    done = 1; @(negedge clk); done = 0;
    chk("R6 idle after done", busy, 0);
    wait_rise(20, t);
    chk("R6 new request after done", t >= 0, 1);

    // R9 saturation
    repeat (2300) @(negedge clk);
    chk("R9 saturate", drop_count, 255);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule